// File: doc/BRIEF.md
# Accumulator Readout Rounding Formatter

This block turns a 48-bit extended multiply-accumulate register into the 32-bit word that a store instruction writes to a general-purpose register. The accumulator is split into three parts. The top 8 bits are extension bits. The middle 32 bits are the visible word. The bottom 8 bits are guard bits that lie below the visible word's least significant bit. On a store strobe, the block samples the accumulator and three mode bits: fraction/integer, unsigned-select and round/truncate. It then registers the formatted word together with a valid flag.

There are three readout formats:

- **Visible word.** Integer mode, or fractional truncate mode, sends the visible word out unchanged.
- **32-bit rounded fraction.** Fractional mode with the round bit set and unsigned-select clear rounds the visible word to nearest-even using the guard bits.
- **16-bit rounded fraction.** Fractional mode with unsigned-select set rounds the top half of the visible word to nearest-even using the 24 bits below it. The result goes into the low half-word, and the high half-word is zero.

A positive value that would round past the largest positive code is held at that code. The block only reads the accumulator and never changes it.

Top module: `acc_readout_fmt`

## Requirements
- R1: With the fraction mode bit clear, the result is acc_i[39:8], whatever the other mode bits are.
- R2: With fraction set, unsigned-select clear and round clear, the result is acc_i[39:8], and acc_i[7:0] is dropped.
- R3: With fraction set, unsigned-select clear and round set, the result is acc_i[39:8] rounded by acc_i[7:0]. Guard above 0x80 rounds up, guard below 0x80 rounds down, and guard equal to 0x80 rounds to the even result (bit 0 = 0).
- R4: In the R3 format, when acc_i[39:8] is 0x7FFF_FFFF and rounding would go up, the result stays 0x7FFF_FFFF.
- R5: With fraction and unsigned-select both set, result[15:0] is acc_i[39:24] rounded to nearest-even by acc_i[23:0], with the tie at 0x80_0000. The round bit has no effect in this format.
- R6: In the R5 format, result[31:16] is zero.
- R7: In the R5 format, when acc_i[39:24] is 0x7FFF and rounding would go up, result[15:0] stays 0x7FFF.
- R8: valid_o is high in exactly the cycle after a cycle where store_i is high, and low otherwise.
- R9: result_o keeps its value in every cycle that follows a cycle without store_i.
- R10: While rst_n is low, result_o is zero and valid_o is low.
- R11: The extension bits acc_i[47:40] have no effect on result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 48 | Extended accumulator: extension [47:40], visible word [39:8], guard [7:0] |
| frac_mode_i | input | 1 | 1 = fractional operands, 0 = integer |
| uns_sel_i | input | 1 | In fractional mode, 1 selects the 16-bit rounded readout |
| rnd_mode_i | input | 1 | 1 = round to nearest-even, 0 = truncate |
| store_i | input | 1 | Store strobe; samples the accumulator and the mode bits |
| result_o | output | 32 | Formatted register word |
| valid_o | output | 1 | High for one cycle after each store strobe |

## Verification
Every combination of the three mode bits is tried with all 256 guard-byte values over a set of visible words. That set includes zero, the smallest odd and even codes, the largest positive code, the most negative code, all-ones, and words whose low half-word sits at, just below or just above the 16-bit tie point.

The full guard sweep on odd and even words separates round-to-nearest-even from round-half-up and from truncation. The largest positive words confirm that the output is held at that code instead of wrapping. The all-ones words confirm that a small negative value wraps to zero.

Alternating the extension byte between stores confirms that those bits have no effect. The idle cycle after each store confirms that the valid flag lasts one cycle and that the result is held.

// File: rtl/acc_readout_fmt_pkg.sv
package acc_readout_fmt_pkg;

  typedef enum logic [1:0] {
    PATH_WORD  = 2'd0,
    PATH_RND32 = 2'd1,
    PATH_RND16 = 2'd2
  } fmt_path_e;

endpackage

// File: rtl/acc_rne_rounder.sv
module acc_rne_rounder #(
  parameter int KEEP_W = 32,
  parameter int DROP_W = 8
) (
  input  logic [KEEP_W+DROP_W-1:0] val_i,
  output logic [KEEP_W-1:0]        rnd_o
);

  localparam int IN_W = KEEP_W + DROP_W;
  localparam logic [DROP_W-1:0] HALF   = {1'b1, {(DROP_W-1){1'b0}}};
  localparam logic [KEEP_W-1:0] MAXPOS = {1'b0, {(KEEP_W-1){1'b1}}};

  logic [KEEP_W-1:0] keep;
  logic [DROP_W-1:0] drop;
  logic              go_up;
  logic              at_max;

  always_comb begin
    keep   = val_i[IN_W-1:DROP_W];
    drop   = val_i[DROP_W-1:0];
    go_up  = (drop > HALF) || ((drop == HALF) && keep[0]);
    at_max = (keep == MAXPOS);
    rnd_o  = (go_up && !at_max) ? keep + KEEP_W'(1) : keep;
  end

endmodule

// File: rtl/acc_fmt_decode.sv
module acc_fmt_decode
  import acc_readout_fmt_pkg::*;
(
  input  logic      frac_mode_i,
  input  logic      uns_sel_i,
  input  logic      rnd_mode_i,
  output fmt_path_e path_o
);

  always_comb begin
    if (!frac_mode_i)    path_o = PATH_WORD;
    else if (uns_sel_i)  path_o = PATH_RND16;
    else if (rnd_mode_i) path_o = PATH_RND32;
    else                 path_o = PATH_WORD;
  end

endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt
  import acc_readout_fmt_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int OUT_W   = 32,
  parameter int GUARD_W = 8,
  parameter int HALF_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             frac_mode_i,
  input  logic             uns_sel_i,
  input  logic             rnd_mode_i,
  input  logic             store_i,
  output logic [OUT_W-1:0] result_o,
  output logic             valid_o
);

  localparam int VIS_W  = OUT_W + GUARD_W;
  localparam int DROP16 = VIS_W - HALF_W;

  logic [VIS_W-1:0]  vis;
  logic [OUT_W-1:0]  word_raw;
  logic [OUT_W-1:0]  word_r32;
  logic [HALF_W-1:0] half_r16;
  logic [OUT_W-1:0]  result_d;
  logic [OUT_W-1:0]  result_q;
  logic              valid_q;
  fmt_path_e         path;

  assign vis      = acc_i[VIS_W-1:0];
  assign word_raw = vis[VIS_W-1:GUARD_W];

  generate
    if (ACC_W > VIS_W) begin : g_ext
      logic ext_unused;
      assign ext_unused = ^acc_i[ACC_W-1:VIS_W];
    end
  endgenerate

  acc_fmt_decode u_decode (
    .frac_mode_i (frac_mode_i),
    .uns_sel_i   (uns_sel_i),
    .rnd_mode_i  (rnd_mode_i),
    .path_o      (path)
  );

  acc_rne_rounder #(.KEEP_W(OUT_W), .DROP_W(GUARD_W)) u_rnd32 (
    .val_i (vis),
    .rnd_o (word_r32)
  );

  acc_rne_rounder #(.KEEP_W(HALF_W), .DROP_W(DROP16)) u_rnd16 (
    .val_i (vis),
    .rnd_o (half_r16)
  );

  always_comb begin
    case (path)
      PATH_RND32: result_d = word_r32;
      PATH_RND16: result_d = {{(OUT_W-HALF_W){1'b0}}, half_r16};
      default:    result_d = word_raw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= store_i;
      if (store_i) begin
        result_q <= result_d;
      end
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/acc_readout_fmt_chk.sv
module acc_readout_fmt_chk #(
  parameter int ACC_W   = 48,
  parameter int OUT_W   = 32,
  parameter int GUARD_W = 8,
  parameter int HALF_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] acc_i,
  input logic             frac_mode_i,
  input logic             uns_sel_i,
  input logic             rnd_mode_i,
  input logic             store_i,
  input logic [OUT_W-1:0] result_o,
  input logic             valid_o
);

  localparam int VIS_W = OUT_W + GUARD_W;
  localparam logic [OUT_W-1:0]  MAX32 = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] MAX16 = {1'b0, {(HALF_W-1){1'b1}}};

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (result_o == '0 && !valid_o); // R10
    end
  end

  AST_VALID_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    store_i |=> valid_o); // R8
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !store_i |=> !valid_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !store_i |=> $stable(result_o)); // R9
  AST_INT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && !frac_mode_i) |=> result_o == $past(acc_i[VIS_W-1:GUARD_W])); // R1
  AST_TRUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && frac_mode_i && !uns_sel_i && !rnd_mode_i)
      |=> result_o == $past(acc_i[VIS_W-1:GUARD_W])); // R2
  AST_CLAMP32: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && frac_mode_i && !uns_sel_i && rnd_mode_i && acc_i[VIS_W-1:GUARD_W] == MAX32)
      |=> result_o == MAX32); // R4
  AST_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && frac_mode_i && uns_sel_i) |=> result_o[OUT_W-1:HALF_W] == '0); // R6
  AST_R16_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && frac_mode_i && uns_sel_i)
      |=> (result_o[HALF_W-1:0] == $past(acc_i[VIS_W-1:VIS_W-HALF_W])) ||
          (result_o[HALF_W-1:0] == $past(acc_i[VIS_W-1:VIS_W-HALF_W]) + HALF_W'(1))); // R5
  AST_CLAMP16: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && frac_mode_i && uns_sel_i && acc_i[VIS_W-1:VIS_W-HALF_W] == MAX16)
      |=> result_o[HALF_W-1:0] == MAX16); // R7

endmodule

bind acc_readout_fmt acc_readout_fmt_chk #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .GUARD_W(GUARD_W), .HALF_W(HALF_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_i       (acc_i),
  .frac_mode_i (frac_mode_i),
  .uns_sel_i   (uns_sel_i),
  .rnd_mode_i  (rnd_mode_i),
  .store_i     (store_i),
  .result_o    (result_o),
  .valid_o     (valid_o)
);

// File: tb/acc_readout_fmt_bench.sv
module acc_readout_fmt_bench;

  logic        clk;
  logic        rst_n;
  logic [47:0] acc;
  logic        frac, uns, rnd, store;
  logic [31:0] result;
  logic        valid;
  int          n_tests;
  int          n_fail;
  bit          done;

  acc_readout_fmt u_acc_readout_fmt (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (acc),
    .frac_mode_i (frac),
    .uns_sel_i   (uns),
    .rnd_mode_i  (rnd),
    .store_i     (store),
    .result_o    (result),
    .valid_o     (valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_pat(input int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'h0000_0002;
      3:  return 32'h7FFF_FFFF;
      4:  return 32'h8000_0000;
      5:  return 32'hFFFF_FFFF;
      6:  return 32'h7FFF_8000;
      7:  return 32'h0002_8000;
      8:  return 32'h0003_8000;
      9:  return 32'h0003_7FFF;
      10: return 32'h1234_8001;
      default: return 32'hFFFF_8000;
    endcase
  endfunction

  function automatic logic [31:0] expect_val(input logic [47:0] a, input bit f,
                                             input bit u, input bit r);
    longint unsigned v, q;
    v = longint'(a[39:0]);
    if (!f || (!u && !r)) return a[39:8];
    if (!u) begin
      q = (v + 64'd128) >> 8;
      if (a[7:0] == 8'h80 && q[0]) q = q - 1;
      if (a[39:8] == 32'h7FFF_FFFF && q == 64'h8000_0000) return 32'h7FFF_FFFF;
      return q[31:0];
    end
    q = (v + 64'h80_0000) >> 24;
    if (a[23:0] == 24'h80_0000 && q[0]) q = q - 1;
    if (a[39:24] == 16'h7FFF && q == 64'h8000) return 32'h0000_7FFF;
    return {16'h0, q[15:0]};
  endfunction

  function automatic string tag_of(input logic [47:0] a, input bit f, input bit u,
                                   input bit r);
    if (!f) return "R1";
    if (!u && !r) return "R2";
    if (!u) return (a[39:8] == 32'h7FFF_FFFF) ? "R4" : "R3";
    return (a[39:24] == 16'h7FFF) ? "R7" : "R5";
  endfunction

  task automatic do_store(input logic [47:0] a, input bit f, input bit u, input bit r);
    logic [31:0] e;
    e = expect_val(a, f, u, r);
    @(negedge clk);
    acc = a; frac = f; uns = u; rnd = r; store = 1'b1;
    @(negedge clk);
    store = 1'b0;
    acc = ~a;
    check(valid === 1'b1, "R8 valid after store", {31'b0, valid}, 32'd1);
    check(result === e, tag_of(a, f, u, r), result, e);
    if (f && u) check(result[31:16] === 16'h0, "R6", result, e);
    @(negedge clk);
    check(valid === 1'b0, "R8 valid one cycle", {31'b0, valid}, 32'd0);
    check(result === e, "R9 hold", result, e);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; acc = '0; frac = 0; uns = 0; rnd = 0; store = 1'b0;
    repeat (3) @(negedge clk);
    check(result === 32'h0 && valid === 1'b0, "R10 reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid === 1'b0, "R8 idle after reset", {31'b0, valid}, 32'd0);

    for (int m = 0; m < 8; m++) begin
      for (int w = 0; w < 12; w++) begin
        for (int g = 0; g < 256; g++) begin
          logic [7:0] ext;
          ext = g[0] ? 8'hA5 : 8'h00;
          do_store({ext, word_pat(w), g[7:0]}, m[2], m[1], m[0]);
        end
      end
    end

    // R11: extension byte does not change the readout
    do_store({8'h00, 32'h1234_5678, 8'h80}, 1, 0, 1);
    ra = result;
    do_store({8'hFF, 32'h1234_5678, 8'h80}, 1, 0, 1);
    rb = result;
    check(ra === rb && ra === 32'h1234_5678, "R11 extension ignored", rb, ra);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule